// File: doc/BRIEF.md
# Energy Pulse Output Generator

This block converts streams of signed energy increments into active-low output pulses. The pulse rate follows the accumulated energy, in the way a digital-to-frequency converter works. Each output channel has its own increment stream and its own signed accumulator. When an accumulator reaches a shared denominator, that denominator is subtracted and one output pulse is requested. A request that arrives while the output is still low is queued. It is issued once the output has returned high for at least one clock.

All timing is counted in ticks of a millisecond strobe. Each output has a mode bit that sets its low-time:
- **Programmable mode:** the low-time comes from a shared 19-bit width value.
- **Default mode:** the low-time is a fixed 80 ticks when the pulse rate is slow. At faster rates it is half the measured request period, which gives roughly 50 % duty.

After enable, a settle timer keeps both accumulators frozen for a selectable time. A clear strobe empties both accumulators, drops queued requests and returns both outputs high.

Top module: `energy_pulse_gen`

## Requirements
- R1: After reset every `pulse_n` bit is 1, and no pulse appears until increments are applied.
- R2: While running, each valid increment is added to its channel's accumulator. Whenever the sum is at least `den`, `den` is subtracted and one pulse is issued. A total of S therefore yields floor(S/den) pulses.
- R3: Negative increments lower the accumulator and never produce a pulse. Later positive increments must first recover the deficit.
- R4: With the channel's `width_mode` bit = 1, the output stays low for exactly `low_ticks` ticks. A value of 0 is treated as 1 tick.
- R5: With `width_mode` = 0, the output stays low for 80 ticks when the measured request period is 160 ticks or more. The first pulse after reset or clear also gets 80 ticks.
- R6: With `width_mode` = 0 and a measured request period P below 160 ticks, the output stays low for P/2 ticks, rounded down and at least 1.
- R7: Requests that arrive while the output is low are queued, up to 15. Each queued request becomes its own low pulse, and every pulse is separated from the next by at least one high clock.
- R8: `settle_sel` picks the delay between enable and the start of accumulation: code 0 = 64 ticks, 1 = 128 ticks, 2 = 256 ticks, 3 = none.
- R9: A one-cycle `clear_req` raises an internal clear that lasts exactly one cycle. The clear empties both accumulators and drops queued requests. Both outputs are high two clocks after the strobe.
- R10: Each output's low-time follows its own `width_mode` bit, independently of the other output.
- R11: While `enable` = 0, increments are ignored and the settle timer restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| enable | input | 1 | Run enable; rising starts settle timer |
| settle_sel | input | 2 | Settle delay code (R8) |
| clear_req | input | 1 | One-cycle accumulator clear strobe |
| den | input | 24 | Pulse threshold, shared by both channels |
| width_mode | input | 2 | Per-output low-time mode, bit n for output n |
| low_ticks | input | 19 | Shared programmable low-time in ticks |
| inc_valid | input | 2 | Per-channel increment valid |
| inc_data | input | 48 | Signed increments, channel n in bits [24n+23:24n] |
| pulse_n | output | 2 | Active-low pulse outputs |

## Verification
The assertions assume the following about the inputs:
- `tick_ms` pulses for one cycle at a time.
- Each positive increment stays at or below `den`, so one subtraction per update is enough.
- `den` does not change while pulses are being counted.

The bench keeps within these limits. It generates the tick from a free-running divider, and it never drives an increment larger than the denominator it has programmed. For the period-dependent default width, it presents increments only on tick cycles, so the request period is an exact number of ticks. It reprograms the denominator, modes and settle code only while no increments are flowing, and follows each change with a clear.

// File: rtl/epg_pkg.sv
package epg_pkg;

  typedef enum logic [1:0] {
    SETTLE_SHORT = 2'd0,
    SETTLE_MID   = 2'd1,
    SETTLE_LONG  = 2'd2,
    SETTLE_NONE  = 2'd3
  } settle_code_e;

  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } pulse_phase_e;

endpackage

// File: rtl/epg_settle_timer.sv
module epg_settle_timer
  import epg_pkg::*;
#(
  parameter int LIM_SHORT = 64,
  parameter int LIM_MID   = 128,
  parameter int LIM_LONG  = 256,
  localparam int CNT_W    = $clog2(LIM_LONG + 1)
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       done_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             done_q, done_d;

  always_comb begin
    case (settle_code_e'(sel_i))
      SETTLE_SHORT: limit = CNT_W'(LIM_SHORT);
      SETTLE_MID:   limit = CNT_W'(LIM_MID);
      SETTLE_LONG:  limit = CNT_W'(LIM_LONG);
      default:      limit = '0;
    endcase
  end

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!en_i) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      if (cnt_q >= limit) begin
        done_d = 1'b1;
      end else if (tick_i) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  a_r11_drop_when_disabled: assert property (@(posedge clk) disable iff (!rst_ni)
    !en_i |=> !done_q);

  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && done_q) |=> done_q);

endmodule

// File: rtl/epg_accum.sv
module epg_accum #(
  parameter int INC_W = 24,
  parameter int DEN_W = 24,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             valid_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             req_o
);

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W-1:0] inc_ext, den_ext, sum;
  logic                    req_q, req_d;
  logic                    upd_en;

  assign inc_ext = {{(ACC_W-INC_W){inc_i[INC_W-1]}}, inc_i};
  assign den_ext = {{(ACC_W-DEN_W){1'b0}}, den_i};
  assign sum     = acc_q + inc_ext;
  assign upd_en  = run_i && valid_i;

  always_comb begin
    acc_d = acc_q;
    req_d = 1'b0;
    if (clr_i) begin
      acc_d = '0;
    end else if (upd_en) begin
      if ((den_i != '0) && (sum >= den_ext)) begin
        acc_d = sum - den_ext;
        req_d = 1'b1;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      req_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      req_q <= req_d;
    end
  end

  assign req_o = req_q;

  a_r11_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(acc_q));

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));

  a_r2_req_needs_run: assert property (@(posedge clk) disable iff (!rst_ni)
    req_q |-> $past(run_i));

endmodule

// File: rtl/epg_shaper.sv
module epg_shaper
  import epg_pkg::*;
#(
  parameter int LT_W     = 19,
  parameter int PEND_W   = 4,
  parameter int FIX_LOW  = 80,
  parameter int SLOW_PER = 160,
  localparam int PER_W   = $clog2(SLOW_PER + 1)
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            tick_i,
  input  logic            req_i,
  input  logic            prog_mode_i,
  input  logic [LT_W-1:0] low_ticks_i,
  output logic            pulse_n_o
);

  localparam logic [PER_W-1:0]  PER_MAX  = PER_W'(SLOW_PER);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  pulse_phase_e      phase_q, phase_d;
  logic [LT_W-1:0]   low_cnt_q, low_cnt_d, tgt_q, tgt_d, tgt_sel, half_per;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic [PER_W-1:0]  per_cnt_q, per_cnt_d, per_q, per_d;
  logic              issue, pend_add;

  assign half_per = LT_W'(per_q >> 1);

  always_comb begin
    if (prog_mode_i) begin
      tgt_sel = (low_ticks_i == '0) ? LT_W'(1) : low_ticks_i;
    end else if (per_q >= PER_MAX) begin
      tgt_sel = LT_W'(FIX_LOW);
    end else begin
      tgt_sel = (half_per == '0) ? LT_W'(1) : half_per;
    end
  end

  assign issue    = (phase_q == PH_HIGH) && (pend_q != '0);
  assign pend_add = req_i && (pend_q != PEND_MAX);

  always_comb begin
    phase_d   = phase_q;
    low_cnt_d = low_cnt_q;
    tgt_d     = tgt_q;
    pend_d    = pend_q;
    per_cnt_d = per_cnt_q;
    per_d     = per_q;
    if (clr_i) begin
      phase_d   = PH_HIGH;
      low_cnt_d = '0;
      pend_d    = '0;
      per_cnt_d = PER_MAX;
      per_d     = PER_MAX;
    end else begin
      if (req_i) begin
        per_d     = per_cnt_q;
        per_cnt_d = '0;
      end else if (tick_i && (per_cnt_q < PER_MAX)) begin
        per_cnt_d = per_cnt_q + 1'b1;
      end
      if (pend_add && !issue) begin
        pend_d = pend_q + 1'b1;
      end else if (!pend_add && issue) begin
        pend_d = pend_q - 1'b1;
      end
      if (issue) begin
        phase_d   = PH_LOW;
        low_cnt_d = '0;
        tgt_d     = tgt_sel;
      end else if ((phase_q == PH_LOW) && tick_i) begin
        if (LT_W'(low_cnt_q + 1'b1) >= tgt_q) begin
          phase_d = PH_HIGH;
        end else begin
          low_cnt_d = low_cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_HIGH;
      low_cnt_q <= '0;
      tgt_q     <= '0;
      pend_q    <= '0;
      per_cnt_q <= PER_MAX;
      per_q     <= PER_MAX;
    end else begin
      phase_q   <= phase_d;
      low_cnt_q <= low_cnt_d;
      tgt_q     <= tgt_d;
      pend_q    <= pend_d;
      per_cnt_q <= per_cnt_d;
      per_q     <= per_d;
    end
  end

  assign pulse_n_o = (phase_q != PH_LOW);

  a_r4_low_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(pulse_n_o) && !$past(clr_i)) |-> $past(tick_i));

  a_r9_clear_forces_high: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_i |=> pulse_n_o);

  a_r7_low_needs_request: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(pulse_n_o) |-> $past(pend_q != '0));

endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen #(
  parameter int NUM_OUT   = 2,
  parameter int INC_W     = 24,
  parameter int DEN_W     = 24,
  parameter int ACC_W     = 32,
  parameter int LT_W      = 19,
  parameter int PEND_W    = 4,
  parameter int FIX_LOW   = 80,
  parameter int SLOW_PER  = 160,
  parameter int LIM_SHORT = 64,
  parameter int LIM_MID   = 128,
  parameter int LIM_LONG  = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_ms,
  input  logic                     enable,
  input  logic [1:0]               settle_sel,
  input  logic                     clear_req,
  input  logic [DEN_W-1:0]         den,
  input  logic [NUM_OUT-1:0]       width_mode,
  input  logic [LT_W-1:0]          low_ticks,
  input  logic [NUM_OUT-1:0]       inc_valid,
  input  logic [NUM_OUT*INC_W-1:0] inc_data,
  output logic [NUM_OUT-1:0]       pulse_n
);

  logic rst_meta_q, rst_sync_q;
  logic clr_q;
  logic settled;
  logic [NUM_OUT-1:0] req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      clr_q <= 1'b0;
    end else begin
      clr_q <= clear_req && !clr_q;
    end
  end

  a_r9_clear_one_cycle: assert property (@(posedge clk) disable iff (!rst_sync_q)
    clr_q |=> !clr_q);

  epg_settle_timer #(
    .LIM_SHORT(LIM_SHORT),
    .LIM_MID  (LIM_MID),
    .LIM_LONG (LIM_LONG)
  ) u_settle (
    .clk   (clk),
    .rst_ni(rst_sync_q),
    .en_i  (enable),
    .tick_i(tick_ms),
    .sel_i (settle_sel),
    .done_o(settled)
  );

  for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_chan
    epg_accum #(
      .INC_W(INC_W),
      .DEN_W(DEN_W),
      .ACC_W(ACC_W)
    ) u_accum (
      .clk    (clk),
      .rst_ni (rst_sync_q),
      .clr_i  (clr_q),
      .run_i  (settled && enable),
      .valid_i(inc_valid[ch]),
      .inc_i  (inc_data[ch*INC_W +: INC_W]),
      .den_i  (den),
      .req_o  (req[ch])
    );

    epg_shaper #(
      .LT_W    (LT_W),
      .PEND_W  (PEND_W),
      .FIX_LOW (FIX_LOW),
      .SLOW_PER(SLOW_PER)
    ) u_shaper (
      .clk        (clk),
      .rst_ni     (rst_sync_q),
      .clr_i      (clr_q),
      .tick_i     (tick_ms),
      .req_i      (req[ch]),
      .prog_mode_i(width_mode[ch]),
      .low_ticks_i(low_ticks),
      .pulse_n_o  (pulse_n[ch])
    );
  end

endmodule

// File: tb/test_energy_pulse_gen.sv
module test_energy_pulse_gen;

  localparam int TICK_CYC = 8;

  logic        clk, rst_n, tick_ms, enable, clear_req;
  logic [1:0]  settle_sel, width_mode, task_valid, inc_valid, pulse_n;
  logic [23:0] den, inc_val;
  logic [18:0] low_ticks;
  logic [47:0] inc_data;
  logic        tick_mode;
  int          div_cnt;

  int vectors = 0, miscompares = 0;
  int falls [2];
  int cur_low [2];
  int last_low [2];
  int ticks_seen;
  logic [1:0] prev_n;
  bit finished = 0;

  energy_pulse_gen i_energy_pulse_gen (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .enable(enable),
    .settle_sel(settle_sel), .clear_req(clear_req), .den(den),
    .width_mode(width_mode), .low_ticks(low_ticks), .inc_valid(inc_valid),
    .inc_data(inc_data), .pulse_n(pulse_n)
  );

  assign inc_data  = {inc_val, inc_val};
  assign inc_valid = task_valid | (tick_mode ? {2{tick_ms}} : 2'b00);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      div_cnt <= 0;
      tick_ms <= 1'b0;
    end else begin
      div_cnt <= (div_cnt == TICK_CYC-1) ? 0 : div_cnt + 1;
      tick_ms <= (div_cnt == TICK_CYC-1);
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_n = 2'b11;
      ticks_seen = 0;
      for (int c = 0; c < 2; c++) begin
        falls[c] = 0; cur_low[c] = 0; last_low[c] = 0;
      end
    end else begin
      if (tick_ms) ticks_seen++;
      for (int c = 0; c < 2; c++) begin
        if (prev_n[c] && !pulse_n[c]) cur_low[c] = 0;
        else if (!prev_n[c] && tick_ms) cur_low[c]++;
        if (!prev_n[c] && pulse_n[c]) last_low[c] = cur_low[c];
        if (prev_n[c] && !pulse_n[c]) falls[c]++;
      end
      prev_n = pulse_n;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * TICK_CYC) @(negedge clk);
    #1;
  endtask

  task automatic push(input int val, input int n);
    @(negedge clk);
    inc_val = val[23:0];
    task_valid = 2'b11;
    repeat (n) @(negedge clk);
    task_valid = 2'b00;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clear_req = 1'b1;
    @(negedge clk);
    clear_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    check(pulse_n == 2'b11, "R1 outputs high after reset", int'(pulse_n), 3);
    wait_ticks(20);
    check(falls[0] == 0 && falls[1] == 0, "R1 no pulse without increments", falls[0] + falls[1], 0);
  endtask

  task automatic t_count();
    int f0, f1;
    width_mode = 2'b11; low_ticks = 19'd1; den = 24'd1000;
    pulse_clear();
    f0 = falls[0]; f1 = falls[1];
    push(70, 500);
    wait_ticks(20);
    check(falls[0] - f0 == 35, "R2 pulse count ch0", falls[0] - f0, 35);
    check(falls[1] - f1 == 35, "R2 pulse count ch1", falls[1] - f1, 35);
  endtask

  task automatic t_negative();
    int f0;
    width_mode = 2'b11; low_ticks = 19'd1;
    pulse_clear();
    f0 = falls[0];
    push(70, 300);
    push(-500, 1);
    push(100, 10);
    wait_ticks(10);
    check(falls[0] - f0 == 21, "R3 deficit delays pulse", falls[0] - f0, 21);
    push(100, 5);
    wait_ticks(10);
    check(falls[0] - f0 == 22, "R3 pulse after recovery", falls[0] - f0, 22);
  endtask

  task automatic t_prog_width();
    width_mode = 2'b01; low_ticks = 19'd37;
    pulse_clear();
    push(1000, 1);
    wait_ticks(100);
    check(last_low[0] == 37, "R4 programmed low-time", last_low[0], 37);
    check(last_low[1] == 80, "R10 other output default width", last_low[1], 80);
    low_ticks = 19'd0;
    push(1000, 1);
    wait_ticks(100);
    check(last_low[0] == 1, "R4 zero width means one tick", last_low[0], 1);
  endtask

  task automatic t_default_slow();
    width_mode = 2'b00;
    pulse_clear();
    inc_val = 24'd5;
    tick_mode = 1'b1;
    wait_ticks(450);
    tick_mode = 1'b0;
    wait_ticks(100);
    check(last_low[0] == 80, "R5 slow rate fixed low-time", last_low[0], 80);
    check(falls[1] > 0, "R5 pulses present ch1", falls[1], 2);
  endtask

  task automatic t_default_fast();
    width_mode = 2'b00;
    pulse_clear();
    inc_val = 24'd50;
    tick_mode = 1'b1;
    wait_ticks(300);
    check(last_low[0] == 10, "R6 half of 20-tick period", last_low[0], 10);
    tick_mode = 1'b0;
    pulse_clear();
  endtask

  task automatic t_pending();
    int f0;
    width_mode = 2'b11; low_ticks = 19'd50;
    pulse_clear();
    f0 = falls[0];
    push(1000, 3);
    wait_ticks(200);
    check(falls[0] - f0 == 3, "R7 queued requests each pulse", falls[0] - f0, 3);
    check(last_low[0] == 50, "R7 queued pulse width", last_low[0], 50);
  endtask

  task automatic t_settle();
    int lim [4] = '{64, 128, 256, 0};
    width_mode = 2'b11; low_ticks = 19'd1;
    for (int code = 0; code < 4; code++) begin
      int start, f0, el;
      @(negedge clk);
      enable = 1'b0;
      settle_sel = code[1:0];
      pulse_clear();
      f0 = falls[0];
      @(negedge clk);
      enable = 1'b1;
      inc_val = 24'd1000;
      task_valid = 2'b11;
      #1;
      start = ticks_seen;
      for (int k = 0; k < 4000 && falls[0] == f0; k++) @(negedge clk);
      #1;
      el = ticks_seen - start;
      task_valid = 2'b00;
      check(el >= lim[code] && el <= lim[code] + 1, "R8 settle delay", el, lim[code]);
      pulse_clear();
    end
  endtask

  task automatic t_clear();
    int f0;
    width_mode = 2'b00;
    pulse_clear();
    push(1000, 1);
    wait_ticks(10);
    check(pulse_n == 2'b00, "R9 pulse low before clear", int'(pulse_n), 0);
    @(negedge clk);
    clear_req = 1'b1;
    @(negedge clk);
    clear_req = 1'b0;
    @(negedge clk);
    #1;
    check(pulse_n == 2'b11, "R9 outputs high after clear", int'(pulse_n), 3);
    push(600, 1);
    pulse_clear();
    f0 = falls[0];
    push(600, 1);
    wait_ticks(10);
    check(falls[0] == f0, "R9 accumulator emptied", falls[0] - f0, 0);
    push(400, 1);
    wait_ticks(100);
    check(falls[0] - f0 == 1, "R9 pulse after refill", falls[0] - f0, 1);
  endtask

  task automatic t_enable_low();
    int f0;
    width_mode = 2'b11; low_ticks = 19'd1;
    pulse_clear();
    f0 = falls[0];
    @(negedge clk);
    enable = 1'b0;
    push(1000, 3);
    wait_ticks(10);
    check(falls[0] == f0, "R11 increments ignored while disabled", falls[0] - f0, 0);
    @(negedge clk);
    enable = 1'b1;
    wait_ticks(10);
    check(falls[0] == f0, "R11 nothing stored while disabled", falls[0] - f0, 0);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; clear_req = 1'b0; settle_sel = 2'd3;
    den = 24'd1000; width_mode = 2'b00; low_ticks = 19'd1;
    task_valid = 2'b00; inc_val = '0; tick_mode = 1'b0;
    repeat (10) @(negedge clk);
    check(pulse_n == 2'b11, "R1 outputs high in reset", int'(pulse_n), 3);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    enable = 1'b1;
    t_reset_state();
    t_count();
    t_negative();
    t_prog_width();
    t_default_slow();
    t_default_fast();
    t_pending();
    t_settle();
    t_clear();
    t_enable_low();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog R1..R11 run actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule